// File: doc/BRIEF.md
# Keyed Reset Pulse Generator

This block holds the configuration for an external reset pin and drives the pulse on that pin when the watchdog fires. It has one 32-bit configuration word. Bit 31 selects active-high polarity. Bit 30 selects push-pull drive. The low bits hold the pulse width. A write cannot set the polarity or drive bits directly. Instead, the top byte of the written data must carry a key code, and each key code sets or clears exactly one of those two bits. Every write updates the width field, whatever the top byte holds.

A one-cycle `wdt_fire` request starts a reset pulse that lasts for the programmed width plus one clock cycles. The request is accepted only while no pulse is running. The pad-drive stage turns the pulse into an output level and an output enable. In push-pull mode the enable stays on all the time. In open-drain mode the enable turns on only during the pulse and the level is held low.

The parameter `NEWER_KEYS` chooses between two variants:
- With `NEWER_KEYS` = 1, key decoding is active and the width field is `NEW_FIELD_W` bits.
- With `NEWER_KEYS` = 0, the key bytes are ignored, bits 31:30 stay 0, and the width field is `OLD_FIELD_W` bits.

The pulse controller has two states:
- `ST_IDLE`: no pulse is running.
- `ST_PULSE`: the reset is being asserted.

It has three transitions:
- **fire** (`ST_IDLE` to `ST_PULSE`, on `wdt_fire`): the current width is loaded into the down-counter.
- **count** (`ST_PULSE` to `ST_PULSE`, while the counter is nonzero): the counter decrements.
- **done** (`ST_PULSE` to `ST_IDLE`, when the counter reaches zero).

Top module: `keyed_reset_pulse`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x000000FF and `pulse_busy` is 0. Because bit 30 is 0 (open-drain), `rst_oe` and `rst_level` are both 0.
- R2: In the newer variant, a write whose data bits 31:24 equal 0xA5 sets bit 31 (active-high). A write whose top byte equals 0x5A clears bit 31.
- R3: In the newer variant, a top byte of 0xA8 sets bit 30 (push-pull), and a top byte of 0x8A clears bit 30.
- R4: A write whose top byte is zero, or is any value other than the four key codes, leaves bits 31:30 unchanged.
- R5: Every write loads data bits FIELD_W-1:0 into the width field in the cycle after the write. Bits 29:FIELD_W always read 0. FIELD_W is 20 in the newer variant and 8 in the older one.
- R6: In the older variant (`NEWER_KEYS` = 0), key bytes have no effect and bits 31:30 always read 0.
- R7: A `wdt_fire` sampled high in `ST_IDLE` raises `pulse_busy` from the next cycle. `pulse_busy` then stays high for exactly width+1 cycles.
- R8: A `wdt_fire` that arrives while a pulse is running is ignored. The pulse neither restarts nor gets longer.
- R9: The width is captured when the pulse starts. A write during a pulse does not change that pulse's length, but it does apply to the next pulse.
- R10: With bit 30 set, `rst_oe` is always 1. `rst_level` equals bit 31 during a pulse and its inverse outside one.
- R11: With bit 30 clear, `rst_oe` equals `pulse_busy` and `rst_level` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data: key byte in 31:24, width in the low bits |
| cfg_rdata | output | 32 | Full stored configuration word |
| wdt_fire | input | 1 | Pulse request from the watchdog |
| rst_level | output | 1 | Level to drive on the reset pad |
| rst_oe | output | 1 | Output enable for the reset pad |
| pulse_busy | output | 1 | High while the reset pulse is asserted |

## Verification
The bench builds two copies side by side and drives them with the same writes and triggers:
- `u0` uses the defaults (key decoding on, 20-bit width field). It shows masking to 20 bits, all four key codes and the push-pull level behaviour.
- `u1` uses `NEWER_KEYS` = 0 (8-bit field). It shows key bytes being ignored, truncation to 8 bits, and open-drain enable behaviour on the same pulse.

Both copies are given small widths, including zero, so the exact pulse length and the retrigger and mid-pulse-write cases can be checked cycle by cycle.

// File: rtl/keyed_reset_pkg.sv
package keyed_reset_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } pulse_state_t;

    localparam int CFG_W     = 32;
    localparam int POL_BIT   = 31;
    localparam int DRV_BIT   = 30;
    localparam int KEY_LSB   = 24;
    localparam int KEY_W     = 8;

    localparam logic [KEY_W-1:0] KEY_POL_HIGH  = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_POL_LOW   = 8'h5A;
    localparam logic [KEY_W-1:0] KEY_DRV_PP    = 8'hA8;
    localparam logic [KEY_W-1:0] KEY_DRV_OD    = 8'h8A;

    localparam logic [7:0] WIDTH_RESET = 8'hFF;

endpackage

// File: rtl/krp_cfg_reg.sv
module krp_cfg_reg
    import keyed_reset_pkg::*;
#(
    parameter bit NEWER_KEYS = 1'b1,
    parameter int FIELD_W    = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W-1:0]   cfg_q,
    output logic               pol_high,
    output logic               push_pull,
    output logic [FIELD_W-1:0] width
);

    localparam int PAD_W = DRV_BIT - FIELD_W;

    logic               pol_q, drv_q;
    logic               pol_nxt, drv_nxt;
    logic [FIELD_W-1:0] width_q;
    logic [KEY_W-1:0]   key_byte;
    logic               unused_mid;

    assign key_byte   = wr_data[KEY_LSB +: KEY_W];
    assign unused_mid = ^wr_data[DRV_BIT-1:FIELD_W];

    generate
        if (NEWER_KEYS) begin : g_key_decode
            always_comb begin
                pol_nxt = pol_q;
                drv_nxt = drv_q;
                case (key_byte)
                    KEY_POL_HIGH: pol_nxt = 1'b1;
                    KEY_POL_LOW:  pol_nxt = 1'b0;
                    KEY_DRV_PP:   drv_nxt = 1'b1;
                    KEY_DRV_OD:   drv_nxt = 1'b0;
                    default:      ;
                endcase
            end
        end else begin : g_no_keys
            logic unused_key;
            assign unused_key = ^key_byte;
            assign pol_nxt    = 1'b0;
            assign drv_nxt    = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= 1'b0;
            drv_q   <= 1'b0;
            width_q <= FIELD_W'(WIDTH_RESET);
        end else if (wr_en) begin
            pol_q   <= pol_nxt;
            drv_q   <= drv_nxt;
            width_q <= wr_data[FIELD_W-1:0];
        end
    end

    assign cfg_q     = {pol_q, drv_q, {PAD_W{1'b0}}, width_q};
    assign pol_high  = pol_q;
    assign push_pull = drv_q;
    assign width     = width_q;

endmodule

// File: rtl/krp_pulse_fsm.sv
module krp_pulse_fsm
    import keyed_reset_pkg::*;
#(
    parameter int FIELD_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [FIELD_W-1:0] width,
    output logic               active
);

    pulse_state_t       state_q, state_d;
    logic [FIELD_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state: fire, count, done
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    state_d = ST_PULSE;
                    cnt_d   = width;
                end
            end
            ST_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        active = 1'b0;
        unique case (state_q)
            ST_IDLE:  active = 1'b0;
            ST_PULSE: active = 1'b1;
        endcase
    end

endmodule

// File: rtl/krp_pad_drive.sv
module krp_pad_drive (
    input  logic active,
    input  logic pol_high,
    input  logic push_pull,
    output logic level,
    output logic oe
);

    always_comb begin
        if (push_pull) begin
            oe    = 1'b1;
            level = active ? pol_high : !pol_high;
        end else begin
            oe    = active;
            level = 1'b0;
        end
    end

endmodule

// File: rtl/keyed_reset_pulse.sv
module keyed_reset_pulse
    import keyed_reset_pkg::*;
#(
    parameter bit NEWER_KEYS  = 1'b1,
    parameter int NEW_FIELD_W = 20,
    parameter int OLD_FIELD_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        wdt_fire,
    output logic        rst_level,
    output logic        rst_oe,
    output logic        pulse_busy
);

    localparam int FIELD_W = NEWER_KEYS ? NEW_FIELD_W : OLD_FIELD_W;

    logic               pol_high, push_pull;
    logic [FIELD_W-1:0] width;

    krp_cfg_reg #(
        .NEWER_KEYS (NEWER_KEYS),
        .FIELD_W    (FIELD_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .cfg_q     (cfg_rdata),
        .pol_high  (pol_high),
        .push_pull (push_pull),
        .width     (width)
    );

    krp_pulse_fsm #(
        .FIELD_W (FIELD_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (wdt_fire),
        .width  (width),
        .active (pulse_busy)
    );

    krp_pad_drive u_pad (
        .active    (pulse_busy),
        .pol_high  (pol_high),
        .push_pull (push_pull),
        .level     (rst_level),
        .oe        (rst_oe)
    );

endmodule

// File: rtl/keyed_reset_pulse_chk.sv
module keyed_reset_pulse_chk #(
    parameter bit NEWER_KEYS = 1'b1,
    parameter int FIELD_W    = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        wdt_fire,
    input logic        rst_level,
    input logic        rst_oe,
    input logic        pulse_busy
);

    assert_width_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[FIELD_W-1:0] == $past(cfg_wdata[FIELD_W-1:0]));

    assert_pad_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[29:FIELD_W] == '0);

    assert_zero_key_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[31:24] == 8'h00) |=> $stable(cfg_rdata[31:30]));

    assert_start_needs_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_busy) |-> $past(wdt_fire));

    assert_pp_oe_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[30] |-> rst_oe);

    assert_od_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[30] |-> (!rst_level && (rst_oe == pulse_busy)));

    generate
        if (NEWER_KEYS) begin : g_new
            assert_key_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_wdata[31:24] == 8'hA5) |=> cfg_rdata[31]);
            assert_key_pp_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_wdata[31:24] == 8'hA8) |=> cfg_rdata[30]);
        end else begin : g_old
            assert_no_keys_R6: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_rdata[31:30] == 2'b00);
        end
    endgenerate

endmodule

bind keyed_reset_pulse keyed_reset_pulse_chk #(
    .NEWER_KEYS (NEWER_KEYS),
    .FIELD_W    (FIELD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .wdt_fire   (wdt_fire),
    .rst_level  (rst_level),
    .rst_oe     (rst_oe),
    .pulse_busy (pulse_busy)
);

// File: tb/sim_keyed_reset_pulse.sv
`timescale 1ns/1ps
module sim_keyed_reset_pulse;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        wdt_fire = 1'b0;

    logic [31:0] rd0, rd1;
    logic        lvl0, oe0, busy0, lvl1, oe1, busy1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    keyed_reset_pulse u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd0), .wdt_fire(wdt_fire), .rst_level(lvl0),
        .rst_oe(oe0), .pulse_busy(busy0)
    );

    keyed_reset_pulse #(.NEWER_KEYS(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd1), .wdt_fire(wdt_fire), .rst_level(lvl1),
        .rst_oe(oe1), .pulse_busy(busy1)
    );

    // write data, expected newer readback, expected older readback
    typedef struct packed {
        logic [31:0] wdata;
        logic [31:0] exp_new;
        logic [31:0] exp_old;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'hA5000012, 32'h80000012, 32'h00000012},
        '{32'hA8000034, 32'hC0000034, 32'h00000034},
        '{32'h33FFFFFF, 32'hC00FFFFF, 32'h000000FF},
        '{32'h5A000003, 32'h40000003, 32'h00000003},
        '{32'h8A123456, 32'h00023456, 32'h00000056},
        '{32'h00ABCDEF, 32'h000BCDEF, 32'h000000EF},
        '{32'hA5F00001, 32'h80000001, 32'h00000001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    // fires once, optionally retriggers and writes at iteration mid_at
    task automatic fire(input int mid_at, input logic [31:0] mid_wdata, input bit mid_wr,
                        output int len0, output int len1,
                        output logic [3:0] first_out);
        len0 = 0;
        len1 = 0;
        first_out = '0;
        @(negedge clk);
        wdt_fire = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1;
            if (i == 0) first_out = {lvl0, oe0, lvl1, oe1};
            if (busy0) len0++;
            if (busy1) len1++;
            @(negedge clk);
            wdt_fire  = (i == mid_at);
            cfg_we    = mid_wr && (i == mid_at);
            cfg_wdata = (mid_wr && (i == mid_at)) ? mid_wdata : 32'h0;
        end
        wdt_fire  = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int l0, l1;
        logic [3:0] fo;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 rdata new", rd0, 32'h000000FF);
        check("R1 rdata old", rd1, 32'h000000FF);
        check("R1 idle outputs", {31'd0, busy0, oe0, lvl0}, 32'h0);

        // R2 R3 R4 R5 R6 via table
        for (int k = 0; k < NVEC; k++) begin
            do_write(VECS[k].wdata);
            check("R2/R3/R4/R5 newer readback", rd0, VECS[k].exp_new);
            check("R5/R6 older readback", rd1, VECS[k].exp_old);
        end

        // R3 push-pull, R2 active high, width 3 -> R7 length 4
        do_write(32'hA8000003);
        check("R3 pp set", rd0, 32'hC0000003);
        fire(-1, 32'h0, 1'b0, l0, l1, fo);
        check("R7 length new", 32'(l0), 32'd4);
        check("R7 length old", 32'(l1), 32'd4);
        check("R10 pp active-high pulse level/oe", {30'd0, fo[3:2]}, 32'h3);
        check("R11 open-drain pulse level/oe", {30'd0, fo[1:0]}, 32'h1);
        #1;
        check("R10 pp idle level/oe", {30'd0, lvl0, oe0}, 32'h1);
        check("R11 open-drain idle oe", {31'd0, oe1}, 32'h0);

        // R2 active low push-pull, width 2
        do_write(32'h5A000002);
        check("R2 pol clear", rd0, 32'h40000002);
        fire(-1, 32'h0, 1'b0, l0, l1, fo);
        check("R7 length width 2", 32'(l0), 32'd3);
        check("R10 pp active-low pulse level/oe", {30'd0, fo[3:2]}, 32'h1);
        check("R10 pp active-low idle level", {31'd0, lvl0}, 32'h1);

        // R8 retrigger ignored, R9 mid-pulse write does not shorten
        do_write(32'h00000009);
        check("R4 zero key keeps bits", rd0, 32'h40000009);
        fire(2, 32'h00000001, 1'b1, l0, l1, fo);
        check("R8/R9 length new", 32'(l0), 32'd10);
        check("R8/R9 length old", 32'(l1), 32'd10);
        check("R9 new width stored", rd0, 32'h40000001);
        fire(-1, 32'h0, 1'b0, l0, l1, fo);
        check("R9 next pulse uses new width", 32'(l0), 32'd2);

        // R7 width zero -> single cycle
        do_write(32'h00000000);
        fire(-1, 32'h0, 1'b0, l0, l1, fo);
        check("R7 width zero new", 32'(l0), 32'd1);
        check("R7 width zero old", 32'(l1), 32'd1);

        // R6 older ignores push-pull key
        do_write(32'hA8000005);
        check("R6 old ignores key", rd1, 32'h00000005);
        check("R11 old stays open-drain idle", {30'd0, lvl1, oe1}, 32'h0);

        finish_run();
    end

endmodule